// File: doc/BRIEF.md
# Keypad Row-Scan Press Controller

This block walks a matrix keypad one row at a time and turns a held key into exactly one strobe. It drives a one-hot row pattern and reads a vector of column lines that go high when a key in the driven row is closed. While no column is high it moves on to the next row at every scan tick. When a column is seen high it stops on that row. It latches the column vector and waits two further ticks so the column lines can settle through an external synchronizer. It then fires a single-clock key strobe and parks in a hold phase until the latched column drops.

Each row owns five phases: scan, pressed, synced, strobe and hold. This gives four rows times five phases. The rows are driven in a rotated, non-binary order. The block advances only on clocks where the tick input is high, so it can run from a fast clock with a divided enable or from a slow scan clock with the tick tied high. A scan period of a few milliseconds is what filters contact bounce. Column synchronization and key decoding are done by neighbouring blocks, which combine the strobe, the row drive and the latched column code.

Top module: `kps_scan_fsm`

## Requirements
- R1: While rst_ni is low the block is in the scan phase of row 0, drives row_o = 4'b0100, holds key_stb_o low and clears col_code_o to 0.
- R2: With every column low, each tick moves to the next row in the order 0, 1, 2, 3, 0. Row k drives bit (k+2) mod 4, so the patterns are 0100, 1000, 0001 and 0010.
- R3: row_o is one-hot at all times and keeps the pattern of the current row through all five phases of that row.
- R4: A tick in the scan phase with any column high latches the column vector. The next three ticks then go through pressed, synced and strobe in turn, whatever the columns do, so a press released right after latching still produces a strobe.
- R5: key_stb_o is high only in a clock where the strobe phase meets a tick, so it lasts exactly one clock, and there is exactly one strobe per press however long the key is held.
- R6: In the hold phase the block stays on the same row and gives no further strobe while any latched column is still high.
- R7: When a tick in hold sees no latched column high, the block goes back to the scan phase of the same row. Scanning then resumes with the next row on the following tick.
- R8: A second key closed while the first is still held does not produce a strobe, as long as the first key stays closed.
- R9: col_code_o shows the column vector latched on the press tick (bit c set for column c) and keeps it until the next press is latched.
- R10: On a clock with tick_i low, the state, row_o and col_code_o do not change and no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan tick; the block advances only when high |
| col_i | input | NUM_COLS | Synchronized column lines, high when a key in the driven row is closed |
| row_o | output | NUM_ROWS | One-hot row drive |
| key_stb_o | output | 1 | One-clock strobe for a newly accepted key |
| col_code_o | output | NUM_COLS | Column vector latched at the press |

## Verification
The bench builds the block with its defaults: four rows, four columns and a row rotation of two. These are the values for which the 0100/1000/0001/0010 drive order is defined. A keypad model in the bench feeds each closed key back onto its column only while its own row is driven, so presses are seen only on the correct row. Running the tick every clock and then every third clock covers both the direct slow-clock use and the clock-enable use, including the frozen clocks between ticks. Short presses, long holds, a second key in the held row and a release out of hold show the latch, the single-strobe and the same-row return behaviour.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [2:0] {
    PH_SCAN    = 3'd0,
    PH_PRESSED = 3'd1,
    PH_SYNCED  = 3'd2,
    PH_STROBE  = 3'd3,
    PH_HOLD    = 3'd4
  } kps_phase_e;
endpackage

// File: rtl/kps_row_drive.sv
module kps_row_drive #(
  parameter int NUM_ROWS = 4,
  parameter int ROW_ROT  = 2,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic [ROW_W-1:0]    row_idx_i,
  output logic [NUM_ROWS-1:0] row_o
);
  // rotation is a bijection, so each output bit has exactly one driver
  for (genvar k = 0; k < NUM_ROWS; k++) begin : g_row
    localparam int BIT = (k + ROW_ROT) % NUM_ROWS;
    assign row_o[BIT] = (row_idx_i == ROW_W'(k));
  end
endmodule

// File: rtl/kps_col_track.sv
module kps_col_track #(
  parameter int NUM_COLS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [NUM_COLS-1:0] col_i,
  output logic                any_o,
  output logic                keep_o,
  output logic [NUM_COLS-1:0] code_o
);
  logic [NUM_COLS-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= '0;
    else if (cap_i) code_q <= col_i;
  end

  assign any_o  = |col_i;
  // other columns do not matter: only a latched column keeps the hold alive
  assign keep_o = |(col_i & code_q);
  assign code_o = code_q;
endmodule

// File: rtl/kps_fsm.sv
module kps_fsm
  import kps_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             any_i,
  input  logic             keep_i,
  output logic [ROW_W-1:0] row_idx_o,
  output logic             cap_o,
  output logic             stb_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  kps_phase_e       ph_q, ph_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    ph_d  = ph_q;
    row_d = row_q;
    cap_o = 1'b0;
    if (tick_i) begin
      unique case (ph_q)
        PH_SCAN: begin
          if (any_i) begin
            ph_d  = PH_PRESSED;
            cap_o = 1'b1;
          end else begin
            row_d = (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
          end
        end
        PH_PRESSED: ph_d = PH_SYNCED;
        PH_SYNCED:  ph_d = PH_STROBE;
        PH_STROBE:  ph_d = PH_HOLD;
        PH_HOLD:    if (!keep_i) ph_d = PH_SCAN;  // back to same row
        default:    ph_d = PH_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SCAN;
      row_q <= '0;
    end else begin
      ph_q  <= ph_d;
      row_q <= row_d;
    end
  end

  assign row_idx_o = row_q;
  assign stb_o     = tick_i && (ph_q == PH_STROBE);
endmodule

// File: rtl/kps_scan_fsm.sv
module kps_scan_fsm #(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int ROW_ROT  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_COLS-1:0] col_i,
  output logic [NUM_ROWS-1:0] row_o,
  output logic                key_stb_o,
  output logic [NUM_COLS-1:0] col_code_o
);
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  logic [ROW_W-1:0] row_idx;
  logic             cap, any_col, keep_col;

  kps_fsm #(.NUM_ROWS(NUM_ROWS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .any_i     (any_col),
    .keep_i    (keep_col),
    .row_idx_o (row_idx),
    .cap_o     (cap),
    .stb_o     (key_stb_o)
  );

  kps_col_track #(.NUM_COLS(NUM_COLS)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .col_i  (col_i),
    .any_o  (any_col),
    .keep_o (keep_col),
    .code_o (col_code_o)
  );

  kps_row_drive #(.NUM_ROWS(NUM_ROWS), .ROW_ROT(ROW_ROT)) u_row (
    .row_idx_i (row_idx),
    .row_o     (row_o)
  );
endmodule

// File: rtl/kps_scan_fsm_chk.sv
module kps_scan_fsm_chk #(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int ROW_ROT  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic [NUM_ROWS-1:0] row_o,
  input logic                key_stb_o,
  input logic [NUM_COLS-1:0] col_code_o
);
  localparam logic [NUM_ROWS-1:0] ROW0 = NUM_ROWS'(1) << (ROW_ROT % NUM_ROWS);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (row_o == ROW0 && !key_stb_o && col_code_o == '0));

  p_row_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_o) == 1);

  p_stb_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |-> tick_i);

  p_stb_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |=> !key_stb_o);

  p_hold_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |=> $stable(row_o));

  p_code_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_o |-> $stable(col_code_o));

  p_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(row_o) && $stable(col_code_o)));
endmodule

bind kps_scan_fsm kps_scan_fsm_chk #(
  .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_ROT(ROW_ROT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .row_o      (row_o),
  .key_stb_o  (key_stb_o),
  .col_code_o (col_code_o)
);

// File: tb/kps_scan_fsm_bench.sv
`timescale 1ns/1ps
module kps_scan_fsm_bench;
  localparam int NR = 4, NC = 4, ROT = 2;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [NC-1:0] col = '0;
  logic [NR-1:0] row;
  logic          stb;
  logic [NC-1:0] code;

  kps_scan_fsm #(.NUM_ROWS(NR), .NUM_COLS(NC), .ROW_ROT(ROT)) u_kps_scan_fsm (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .col_i(col),
    .row_o(row), .key_stb_o(stb), .col_code_o(code)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_stb = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // drive patterns stated in R2
  function automatic logic [3:0] pat(input int r);
    case (r)
      0:       return 4'b0100;
      1:       return 4'b1000;
      2:       return 4'b0001;
      default: return 4'b0010;
    endcase
  endfunction

  // keypad model and tick generator, updated away from the active edge
  bit keys [NR][NC];
  int tdiv = 1, tcnt = 0;
  always @(negedge clk) begin
    logic [NC-1:0] c;
    c = '0;
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NC; k++)
        if (keys[r][k] && row[(r + ROT) % NR]) c[k] = 1'b1;
    col  <= c;
    tick <= (tcnt == 0);
    tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  end

  // behavioural reference: phase 0 scan,1 pressed,2 synced,3 strobe,4 hold
  int            m_ph, m_row;
  logic [NC-1:0] m_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_row = 0; m_code = '0;
    end else if (tick) begin
      if (m_ph == 0) begin
        if (col != 0) begin m_ph = 1; m_code = col; end
        else m_row = (m_row + 1) % NR;
      end else if (m_ph == 4) begin
        if ((col & m_code) == 0) m_ph = 0;
      end else m_ph = m_ph + 1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic e_stb;
      e_stb = (m_ph == 3) && tick;
      chk(row == pat(m_row), "row R2 R3 R7", row, pat(m_row));
      chk($countones(row) == 1, "row onehot R3", row, 1);
      chk(stb == e_stb, "strobe R5 R6 R8 R10", stb, e_stb);
      chk(code == m_code, "col code R9", code, m_code);
      if (stb) n_stb++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_key(input int r, input int c, input bit v);
    @(posedge clk); #2;
    keys[r][c] = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int s0;
    logic [NR-1:0] r_hold;
    for (int r = 0; r < NR; r++) for (int k = 0; k < NC; k++) keys[r][k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(row == 4'b0100, "reset row R1", row, 4'b0100);
    chk(stb == 1'b0, "reset strobe R1", stb, 0);
    chk(code == '0, "reset code R1", code, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: idle scan order
    for (int i = 0; i < 8; i++) begin
      wait_cyc(1);
      chk(row == pat((i + 1) % 4), "idle scan R2", row, pat((i + 1) % 4));
    end

    // R5 R9: long press on row 1 column 2
    s0 = n_stb;
    set_key(1, 2, 1);
    wait_cyc(30);
    chk(n_stb - s0 == 1, "one strobe per hold R5", n_stb - s0, 1);
    chk(code == 4'b0100, "latched column R9", code, 4'b0100);
    r_hold = row;
    wait_cyc(10);
    chk(row == r_hold && row == pat(1), "row held in hold R6", row, pat(1));
    set_key(1, 2, 0);
    wait_cyc(10);

    // R8: second key in the held row
    s0 = n_stb;
    set_key(3, 1, 1);
    wait_cyc(20);
    set_key(3, 3, 1);
    wait_cyc(20);
    chk(n_stb - s0 == 1, "second key ignored R8", n_stb - s0, 1);
    @(posedge clk); #2;
    keys[3][1] = 0; keys[3][3] = 0;
    wait_cyc(10);

    // R7: release returns to the same row, then moves on
    set_key(2, 0, 1);
    wait_cyc(20);
    chk(row == pat(2), "hold on row 2 R6", row, pat(2));
    set_key(2, 0, 0);
    wait_cyc(1);
    chk(row == pat(2), "same row after release R7", row, pat(2));
    wait_cyc(1);
    chk(row == pat(3), "next row after release R7", row, pat(3));

    // R4: key released right after it is latched
    s0 = n_stb;
    set_key(0, 3, 1);
    for (int i = 0; i < 50 && m_ph != 1; i++) wait_cyc(1);
    @(posedge clk); #2;
    keys[0][3] = 0;
    wait_cyc(10);
    chk(n_stb - s0 == 1, "short press still strobes R4", n_stb - s0, 1);
    chk(code == 4'b1000, "short press code R9", code, 4'b1000);

    // R10: tick every third clock
    tdiv = 3;
    wait_cyc(6);
    for (int i = 0; i < 12; i++) begin
      logic [NR-1:0] prev;
      prev = row;
      wait_cyc(1);
      if (!tick) chk(row == prev, "frozen without tick R10", row, prev);
    end
    s0 = n_stb;
    set_key(1, 1, 1);
    wait_cyc(60);
    chk(n_stb - s0 == 1, "strobe with slow tick R10", n_stb - s0, 1);
    chk(code == 4'b0010, "slow tick code R9", code, 4'b0010);
    set_key(1, 1, 0);
    wait_cyc(30);

    finish_run();
  end
endmodule